// File: doc/BRIEF.md
# Per-Peripheral Security Access Filter

This block sits in front of a group of peripherals and rules on every bus access in the cycle it arrives. Each access carries a target peripheral index and a secure/non-secure flag. The block holds two 8-bit policy masks. The open mask lists the peripherals that accept non-secure accesses. The block mask lists the peripherals that refuse secure accesses. An access is either granted or answered with an error in the same cycle. There is no wait state.

The two masks are themselves registers of the host control block, and that block occupies peripheral index 2. A read or write of the masks is therefore an ordinary access to index 2 and passes through the same filter. If software refuses every access to index 2, the masks are frozen until the next power-on reset. Power-on reset is the only reset the masks have.

While reset is held, the programmable reset values of bits 0 to 3, 5 and 6 are taken from two init input vectors. The peripheral indices are:
- 0: interrupt controller
- 1: trace unit
- 2: host control block
- 3: unused
- 4: spare
- 5: test RAM
- 6: secondary RAM
- 7: reserved

Top module: `periphGuard`

## Requirements
- R1: With both mask bits of a target at 0, a secure access to it is granted and a non-secure access to it gets an error.
- R2: A 1 in bit t of the open mask grants non-secure accesses to target t.
- R3: A 1 in bit t of the block mask gives an error to secure accesses to target t.
- R4: With block bit t at 1 and open bit t at 0, every access to target t gets an error.
- R5: While accValid is high, exactly one of accGrant and accError is high in that same cycle. While accValid is low, both are low.
- R6: While porRstN is low, the mask bits 0-3, 5 and 6 load from initOpen and initBlock. Open bit 4 resets to 1 and block bit 4 resets to 0. Bit 7 is read-only, reading 1 in the open mask and 0 in the block mask.
- R7: A granted access to target 2 addresses the masks, with accRegSel selecting the mask: 0 is the open mask, 1 is the block mask. A write loads bits 6:0 from accWdata[6:0], ignoring bit 7 and bits 31:8; the new value is visible from the next cycle. A read returns the mask zero-extended to 32 bits. accRdata is 0 for every other access.
- R8: A write that gets an error changes neither mask.
- R9: Once block bit 2 is 1 and open bit 2 is 0, no access can change either mask until porRstN is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous |
| initOpen | input | 8 | Reset values for the open mask, sampled during reset |
| initBlock | input | 8 | Reset values for the block mask, sampled during reset |
| accValid | input | 1 | Access present this cycle |
| accSecure | input | 1 | 1 for a secure access, 0 for a non-secure access |
| accTarget | input | 3 | Target peripheral index |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accRegSel | input | 1 | Mask selector for target 2: 0 open, 1 block |
| accWdata | input | 32 | Write data |
| accGrant | output | 1 | Access permitted |
| accError | output | 1 | Access refused |
| accRdata | output | 32 | Read data of a granted mask read |

## Verification
The assertions check several properties on every cycle. The grant and error responses are exclusive and complete, and both stay quiet while idle. A mask write strobe appears only on a granted access to target 2, and an error response leaves both masks unchanged. Once the host block is shut off from all accesses, both masks hold their values. An access to a peripheral that both masks shut off always gets an error. The bench scenarios show the reset loading of the init vectors and the fixed bits, the readback with its ignored write bits, and the recovery from lockout through power-on reset. They also cover the grant pattern for each mix of mask bits and security flag, compared against a reference model on each clock.

// File: rtl/periphGuardPkg.sv
package periphGuardPkg;
  localparam int MASK_W    = 8;
  localparam int DATA_W    = 32;
  localparam int HOST_IDX  = 2;
  localparam int SPARE_IDX = 4;
  localparam int RSVD_IDX  = 7;

  typedef struct packed {
    logic wrOpen;
    logic wrBlock;
    logic rdEn;
    logic rdSel;
  } guardStrobe_t;
endpackage

// File: rtl/periphGuardCtrl.sv
module periphGuardCtrl
  import periphGuardPkg::*;
#(
  parameter int MW    = MASK_W,
  parameter int HOST  = HOST_IDX,
  localparam int IW   = $clog2(MW)
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic          accValid,
  input  logic          accSecure,
  input  logic [IW-1:0] accTarget,
  input  logic          accWrite,
  input  logic          accRegSel,
  input  logic [MW-1:0] openMask,
  input  logic [MW-1:0] blockMask,
  output logic          accGrant,
  output logic          accError,
  output guardStrobe_t  strobe
);
  logic permit;
  logic hostHit;
  logic hostGrant;

  always_comb begin
    if (accSecure) permit = ~blockMask[accTarget];
    else           permit = openMask[accTarget];
  end

  assign hostHit   = (accTarget == IW'(HOST));
  assign accGrant  = accValid & permit;
  assign accError  = accValid & ~permit;
  assign hostGrant = accGrant & hostHit;

  always_comb begin
    strobe.wrOpen  = hostGrant & accWrite & ~accRegSel;
    strobe.wrBlock = hostGrant & accWrite & accRegSel;
    strobe.rdEn    = hostGrant & ~accWrite;
    strobe.rdSel   = accRegSel;
  end

  // R5
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!porRstN)
    accValid |-> (accGrant ^ accError));
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !accValid |-> (!accGrant && !accError));
  // R8
  wr_needs_grant_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (strobe.wrOpen || strobe.wrBlock) |-> (accGrant && hostHit && accWrite));
  // R8
  denied_write_chk: assert property (@(posedge clk) disable iff (!porRstN)
    accError |=> ($stable(openMask) && $stable(blockMask)));
  // R4
  shut_off_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (accValid && blockMask[accTarget] && !openMask[accTarget]) |-> accError);
endmodule

// File: rtl/periphGuardDp.sv
module periphGuardDp
  import periphGuardPkg::*;
#(
  parameter int MW    = MASK_W,
  parameter int DW    = DATA_W,
  parameter int HOST  = HOST_IDX,
  parameter int SPARE = SPARE_IDX,
  parameter int RSVD  = RSVD_IDX,
  localparam int PAD_W = DW - MW
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic [MW-1:0] initOpen,
  input  logic [MW-1:0] initBlock,
  input  logic [MW-1:0] wrData,
  input  guardStrobe_t  strobe,
  output logic [MW-1:0] openMask,
  output logic [MW-1:0] blockMask,
  output logic [DW-1:0] rdData
);
  logic unusedDpBits;
  assign unusedDpBits = ^{initOpen[SPARE], initOpen[RSVD],
                          initBlock[SPARE], initBlock[RSVD], wrData[RSVD]};

  for (genvar b = 0; b < MW; b++) begin : g_bit
    if (b == RSVD) begin : g_ro
      assign openMask[b]  = 1'b1;
      assign blockMask[b] = 1'b0;
    end else if (b == SPARE) begin : g_fixed
      always_ff @(posedge clk) begin
        if (!porRstN) begin
          openMask[b]  <= 1'b1;
          blockMask[b] <= 1'b0;
        end else begin
          if (strobe.wrOpen)  openMask[b]  <= wrData[b];
          if (strobe.wrBlock) blockMask[b] <= wrData[b];
        end
      end
    end else begin : g_init
      always_ff @(posedge clk) begin
        if (!porRstN) begin
          openMask[b]  <= initOpen[b];
          blockMask[b] <= initBlock[b];
        end else begin
          if (strobe.wrOpen)  openMask[b]  <= wrData[b];
          if (strobe.wrBlock) blockMask[b] <= wrData[b];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdEn) rdData = {{PAD_W{1'b0}}, (strobe.rdSel ? blockMask : openMask)};
  end

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (blockMask[HOST] && !openMask[HOST]) |=> ($stable(openMask) && $stable(blockMask)));
endmodule

// File: rtl/periphGuard.sv
module periphGuard
  import periphGuardPkg::*;
#(
  parameter int MW   = MASK_W,
  parameter int DW   = DATA_W,
  parameter int HOST = HOST_IDX,
  localparam int IW  = $clog2(MW)
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic [MW-1:0] initOpen,
  input  logic [MW-1:0] initBlock,
  input  logic          accValid,
  input  logic          accSecure,
  input  logic [IW-1:0] accTarget,
  input  logic          accWrite,
  input  logic          accRegSel,
  input  logic [DW-1:0] accWdata,
  output logic          accGrant,
  output logic          accError,
  output logic [DW-1:0] accRdata
);
  guardStrobe_t  strobe;
  logic [MW-1:0] openMask;
  logic [MW-1:0] blockMask;
  logic          unusedWdataHi;

  assign unusedWdataHi = ^accWdata[DW-1:MW];

  periphGuardCtrl #(.MW(MW), .HOST(HOST)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .accValid(accValid), .accSecure(accSecure),
    .accTarget(accTarget), .accWrite(accWrite), .accRegSel(accRegSel),
    .openMask(openMask), .blockMask(blockMask),
    .accGrant(accGrant), .accError(accError), .strobe(strobe)
  );

  periphGuardDp #(.MW(MW), .DW(DW), .HOST(HOST)) u_dp (
    .clk(clk), .porRstN(porRstN), .initOpen(initOpen), .initBlock(initBlock),
    .wrData(accWdata[MW-1:0]), .strobe(strobe),
    .openMask(openMask), .blockMask(blockMask), .rdData(accRdata)
  );
endmodule

// File: tb/periphGuard_bench.sv
`timescale 1ns/1ps
module periphGuard_bench;
  logic        clk = 1'b0;
  logic        porRstN;
  logic [7:0]  initOpen, initBlock;
  logic        accValid, accSecure, accWrite, accRegSel;
  logic [2:0]  accTarget;
  logic [31:0] accWdata;
  logic        accGrant, accError;
  logic [31:0] accRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] refOpen, refBlock;

  always #2 clk = ~clk;

  periphGuard u_periphGuard (
    .clk(clk), .porRstN(porRstN), .initOpen(initOpen), .initBlock(initBlock),
    .accValid(accValid), .accSecure(accSecure), .accTarget(accTarget),
    .accWrite(accWrite), .accRegSel(accRegSel), .accWdata(accWdata),
    .accGrant(accGrant), .accError(accError), .accRdata(accRdata)
  );

  task automatic step(input bit v, input bit sec, input logic [2:0] t, input bit wr,
                      input bit sel, input logic [31:0] wd, input string tag);
    bit eg, ee, perm;
    logic [31:0] er;
    @(negedge clk);
    accValid = v; accSecure = sec; accTarget = t; accWrite = wr;
    accRegSel = sel; accWdata = wd;
    #1;
    perm = sec ? !refBlock[t] : refOpen[t];
    eg = v && perm;
    ee = v && !perm;
    er = (eg && t == 3'd2 && !wr) ? {24'h0, (sel ? refBlock : refOpen)} : 32'h0;
    checks++;
    if (accGrant !== eg || accError !== ee || accRdata !== er) begin
      errors++;
      $display("FAIL %s: grant/error/rdata %b/%b/%h expected %b/%b/%h",
               tag, accGrant, accError, accRdata, eg, ee, er);
    end
    @(posedge clk);
    if (eg && t == 3'd2 && wr) begin
      if (sel) refBlock = {1'b0, wd[6:0]};
      else     refOpen  = {1'b1, wd[6:0]};
    end
  endtask

  task automatic doReset(input logic [7:0] io, input logic [7:0] ib);
    @(negedge clk);
    porRstN = 1'b0; accValid = 1'b0; initOpen = io; initBlock = ib;
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    refOpen  = {1'b1, io[6:5], 1'b1, io[3:0]};
    refBlock = {1'b0, ib[6:5], 1'b0, ib[3:0]};
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog: run incomplete, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    porRstN = 1'b0; accValid = 0; accSecure = 0; accTarget = 0;
    accWrite = 0; accRegSel = 0; accWdata = 0; initOpen = 0; initBlock = 0;
    doReset(8'h00, 8'h00);
    // R6 reset values: open reads 0x90, block 0x00
    step(1, 1, 3'd2, 0, 0, 0, "R6");
    step(1, 1, 3'd2, 0, 1, 0, "R6");
    // R1 both bits zero
    step(1, 1, 3'd5, 0, 0, 0, "R1");
    step(1, 0, 3'd5, 1, 0, 0, "R1");
    // R7 write open mask, upper bits and bit 7 ignored
    step(1, 1, 3'd2, 1, 0, 32'hFFFF_FF20, "R7");
    step(1, 1, 3'd2, 0, 0, 0, "R7");
    // R2 non-secure now granted on target 5
    step(1, 0, 3'd5, 0, 0, 0, "R2");
    // R3 block target 1
    step(1, 1, 3'd2, 1, 1, 32'h0000_0002, "R7");
    step(1, 1, 3'd1, 0, 0, 0, "R3");
    step(1, 0, 3'd1, 0, 0, 0, "R4");
    // R5 idle
    step(0, 1, 3'd0, 0, 0, 0, "R5");
    // R8 non-secure write to host refused, then readback
    step(1, 0, 3'd2, 1, 1, 32'h0000_007F, "R8");
    step(1, 1, 3'd2, 0, 1, 0, "R8");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] wd;
      bit sel;
      sel = 1'($urandom_range(0, 1));
      wd = $urandom;
      if (sel) wd[2] = 1'b0; else wd[2] = 1'b1;
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
           3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), sel, wd, "R5");
    end
    // R9 lockout
    step(1, 1, 3'd2, 1, 0, 32'h0000_0000, "R9");
    step(1, 1, 3'd2, 1, 1, 32'h0000_0004, "R9");
    step(1, 1, 3'd2, 1, 1, 32'h0000_0000, "R9");
    step(1, 0, 3'd2, 1, 0, 32'h0000_007F, "R9");
    step(1, 1, 3'd2, 0, 1, 0, "R9");
    for (int i = 0; i < 40; i++)
      step(1, 1'($urandom_range(0, 1)), 3'd2, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom, "R9");
    // R9 recovery through power-on reset, R6 with other init values
    doReset(8'h6F, 8'h41);
    step(1, 1, 3'd2, 0, 0, 0, "R9");
    step(1, 1, 3'd2, 0, 1, 0, "R6");
    step(1, 1, 3'd0, 0, 0, 0, "R3");
    step(1, 0, 3'd6, 0, 0, 0, "R2");
    step(1, 0, 3'd7, 0, 0, 0, "R6");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule